// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block lets host logic hand a command to an embedded processor through a word-wide local RAM that both sides share. When a request is accepted, the block first zeroes the completion word. It then stores the 32-bit argument as two 16-bit halves and writes the command code last. After that it raises a one-cycle doorbell toward the processor. The processor is expected to write a non-zero completion code into the completion word. The block reads that word at a fixed interval until it sees a non-zero value or until it has used up its read budget. It then reports the code it read, whether the wait timed out, and whether the outcome counts as a failure.

A second request kind runs a bus reset as two chained commands. The start command is issued first, then the block waits for a programmable hold time, then it issues the end command. Both commands carry a zero argument. If the start command does not return the success code, the block stops at once and never issues the end command. The read interval and the read budget are parameters, so a bench can shrink them. Their defaults give about five million reads spaced 20 µs apart at 250 MHz.

Top module: `mbox_cmd_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `doorbell`, `ram_we` and `ram_re` are all low.
- R2: An accepted request produces four RAM writes in four consecutive cycles, starting the cycle after acceptance, in this order: 0 to `STATUS_ADDR`, the argument's bits 15:0 to `PARAM_ADDR`, the argument's bits 31:16 to `PARAM_ADDR+1`, and the command code to `CMD_ADDR`. `doorbell` is high for exactly the one cycle after the command write.
- R3: The first read of `STATUS_ADDR` is issued in the cycle after the doorbell. Each later read follows the previous one by `POLL_GAP+2` cycles. Polling stops at the first read that returns a non-zero value.
- R4: If `MAX_POLLS` consecutive reads all return zero, the block finishes with `done_timeout`=1, `done_status`=0 and `done_fail`=1.
- R5: `done` is a one-cycle pulse that comes two cycles after the read that decides the outcome. `done_status` holds the value that read returned. `done_fail` is 1 exactly when the status differs from `SUCCESS_CODE` (1).
- R6: A request raised while `busy` is high is ignored. It causes no RAM write, no doorbell and no extra `done`.
- R7: A bus-reset request (`req_bus_reset`=1) issues `RST_START_CODE` with a zero argument. When that command returns the success code, the block waits and then writes 0 to the status word of the `RST_END_CODE` command `req_hold+3` cycles after the last status read of the start command. The end command also carries a zero argument. `req_cmd` and `req_param` have no effect on a bus-reset request.
- R8: If the start command of a bus reset returns a non-success code or times out, the end command is never issued. `done` then reports the start command's outcome.
- R9: A bus reset that reaches its end command reports the end command's status and timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; taken only while idle |
| req_bus_reset | input | 1 | 1 selects the two-command bus reset |
| req_cmd | input | 16 | Command code for a single command |
| req_param | input | 32 | Argument for a single command |
| req_hold | input | HOLD_W | Hold time of the bus reset, in cycles |
| busy | output | 1 | A sequence is in flight |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 16 | Last completion code read (0 on timeout) |
| done_timeout | output | 1 | The read budget ran out |
| done_fail | output | 1 | Status differs from the success code |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable; data returns next cycle |
| ram_addr | output | AW | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after `ram_re` |
| doorbell | output | 1 | Notification pulse to the processor |

## Verification
The bench sweeps the number of zero reads from none up to the full budget, and combines it with several completion codes. An off-by-one in the read budget would show up as one read too many or too few, or as a timeout on the very read that should succeed. The processor model captures the shared RAM at the doorbell. If the argument were written after the command, or the status were not cleared, the captured words would be stale. Bus-reset runs vary the hold time and place a failure or a timeout in each phase. A sequencer that ignored a bad start would still issue the end command. Wrong hold counting would move the second status clear. A busy-time request that slipped through would show up as extra writes or an extra completion.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CLR,
      ST_PLO,
      ST_PHI,
      ST_CMD,
      ST_BELL,
      ST_RD,
      ST_CHK,
      ST_GAP,
      ST_HOLD
   } mbox_state_e;
endpackage

// File: rtl/mbox_down_cnt.sv
module mbox_down_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         en,
   output logic [W-1:0] count,
   output logic         zero
);
   generate
      if (W < 1) begin : g_bad_width
         $error("mbox_down_cnt: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (en && (count != '0)) begin
         count <= count - 1'b1;
      end
   end

   assign zero = (count == '0);
endmodule

// File: rtl/mbox_port_mux.sv
module mbox_port_mux import mbox_pkg::*; #(
   parameter int AW          = 8,
   parameter int STATUS_ADDR = 16,
   parameter int CMD_ADDR    = 17,
   parameter int PARAM_ADDR  = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  mbox_state_e   state,
   input  logic [15:0]   cmd_word,
   input  logic [31:0]   arg_word,
   output logic          we,
   output logic          re,
   output logic [AW-1:0] addr,
   output logic [15:0]   wdata,
   output logic          bell
);
   localparam logic [AW-1:0] A_STAT = AW'(STATUS_ADDR);
   localparam logic [AW-1:0] A_CMD  = AW'(CMD_ADDR);
   localparam logic [AW-1:0] A_ALO  = AW'(PARAM_ADDR);
   localparam logic [AW-1:0] A_AHI  = AW'(PARAM_ADDR + 1);

   always_comb begin
      we    = 1'b0;
      re    = 1'b0;
      addr  = A_STAT;
      wdata = '0;
      bell  = 1'b0;
      case (state)
         ST_CLR: begin
            we    = 1'b1;
            addr  = A_STAT;
            wdata = '0;
         end
         ST_PLO: begin
            we    = 1'b1;
            addr  = A_ALO;
            wdata = arg_word[15:0];
         end
         ST_PHI: begin
            we    = 1'b1;
            addr  = A_AHI;
            wdata = arg_word[31:16];
         end
         ST_CMD: begin
            we    = 1'b1;
            addr  = A_CMD;
            wdata = cmd_word;
         end
         ST_BELL: bell = 1'b1;
         ST_RD: begin
            re   = 1'b1;
            addr = A_STAT;
         end
         default: ;
      endcase
   end

   // R3: a read never shares a cycle with a write
   assert_rw_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && re));

   // R2: the high argument half directly follows the low half
   assert_arg_halves_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_ALO) |=> (we && addr == A_AHI));
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq import mbox_pkg::*; #(
   parameter int          AW             = 8,
   parameter int          STATUS_ADDR    = 16,
   parameter int          CMD_ADDR       = 17,
   parameter int          PARAM_ADDR     = 18,
   parameter int          MAX_POLLS      = 5000000,
   parameter int          POLL_GAP       = 5000,
   parameter int          HOLD_W         = 24,
   parameter logic [15:0] SUCCESS_CODE   = 16'h0001,
   parameter logic [15:0] RST_START_CODE = 16'h0008,
   parameter logic [15:0] RST_END_CODE   = 16'h0009
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_bus_reset,
   input  logic [15:0]       req_cmd,
   input  logic [31:0]       req_param,
   input  logic [HOLD_W-1:0] req_hold,
   output logic              busy,
   output logic              done,
   output logic [15:0]       done_status,
   output logic              done_timeout,
   output logic              done_fail,
   output logic              ram_we,
   output logic              ram_re,
   output logic [AW-1:0]     ram_addr,
   output logic [15:0]       ram_wdata,
   input  logic [15:0]       ram_rdata,
   output logic              doorbell
);
   localparam int GAP_W = (POLL_GAP  > 1) ? $clog2(POLL_GAP + 1)  : 1;
   localparam int TRY_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS + 1) : 1;
   localparam logic [AW-1:0] A_STAT = AW'(STATUS_ADDR);
   localparam logic [AW-1:0] A_CMD  = AW'(CMD_ADDR);
   localparam logic [AW-1:0] A_ALO  = AW'(PARAM_ADDR);

   generate
      if (MAX_POLLS < 1) begin : g_bad_polls
         $error("mbox_cmd_seq: MAX_POLLS must be at least 1");
      end
      if (POLL_GAP < 1) begin : g_bad_gap
         $error("mbox_cmd_seq: POLL_GAP must be at least 1");
      end
      if (PARAM_ADDR + 1 >= (1 << AW) || STATUS_ADDR >= (1 << AW) || CMD_ADDR >= (1 << AW)) begin : g_bad_addr
         $error("mbox_cmd_seq: mailbox address outside the RAM");
      end
      if (STATUS_ADDR == CMD_ADDR || STATUS_ADDR == PARAM_ADDR || STATUS_ADDR == PARAM_ADDR + 1 ||
          CMD_ADDR == PARAM_ADDR || CMD_ADDR == PARAM_ADDR + 1) begin : g_bad_overlap
         $error("mbox_cmd_seq: mailbox words overlap");
      end
      if (SUCCESS_CODE == 16'h0000) begin : g_bad_success
         $error("mbox_cmd_seq: success code must be non-zero");
      end
   endgenerate

   mbox_state_e       state;
   logic [15:0]       cmd_q;
   logic [31:0]       arg_q;
   logic [HOLD_W-1:0] hold_q;
   logic              rst_mode_q;
   logic              phase2_q;

   logic              st_zero;
   logic              gap_load, gap_en, gap_zero;
   logic              try_load, try_en, try_zero;
   logic              hold_load, hold_en, hold_zero;
   logic              chain_go;
   logic [GAP_W-1:0]  gap_count;
   logic [TRY_W-1:0]  try_count;
   logic [HOLD_W-1:0] hold_count;

   assign st_zero   = (ram_rdata == 16'h0000);
   assign chain_go  = rst_mode_q && !phase2_q && (ram_rdata == SUCCESS_CODE);
   assign gap_load  = (state == ST_CHK) && st_zero && !try_zero;
   assign gap_en    = (state == ST_GAP);
   assign try_load  = (state == ST_BELL);
   assign try_en    = (state == ST_CHK) && st_zero;
   assign hold_load = (state == ST_CHK) && !st_zero && chain_go;
   assign hold_en   = (state == ST_HOLD);
   assign busy      = (state != ST_IDLE);

   mbox_down_cnt #(.W(GAP_W)) u_gap (
      .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(GAP_W'(POLL_GAP - 1)),
      .en(gap_en), .count(gap_count), .zero(gap_zero));

   mbox_down_cnt #(.W(TRY_W)) u_try (
      .clk(clk), .rst_n(rst_n), .load(try_load), .load_val(TRY_W'(MAX_POLLS - 1)),
      .en(try_en), .count(try_count), .zero(try_zero));

   mbox_down_cnt #(.W(HOLD_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(hold_load), .load_val(hold_q),
      .en(hold_en), .count(hold_count), .zero(hold_zero));

   mbox_port_mux #(
      .AW(AW), .STATUS_ADDR(STATUS_ADDR), .CMD_ADDR(CMD_ADDR), .PARAM_ADDR(PARAM_ADDR)
   ) u_mux (
      .clk(clk), .rst_n(rst_n), .state(state), .cmd_word(cmd_q), .arg_word(arg_q),
      .we(ram_we), .re(ram_re), .addr(ram_addr), .wdata(ram_wdata), .bell(doorbell));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         cmd_q        <= '0;
         arg_q        <= '0;
         hold_q       <= '0;
         rst_mode_q   <= 1'b0;
         phase2_q     <= 1'b0;
         done         <= 1'b0;
         done_status  <= '0;
         done_timeout <= 1'b0;
         done_fail    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  rst_mode_q <= req_bus_reset;
                  phase2_q   <= 1'b0;
                  hold_q     <= req_hold;
                  cmd_q      <= req_bus_reset ? RST_START_CODE : req_cmd;
                  arg_q      <= req_bus_reset ? 32'h0 : req_param;
                  state      <= ST_CLR;
               end
            end
            ST_CLR:  state <= ST_PLO;
            ST_PLO:  state <= ST_PHI;
            ST_PHI:  state <= ST_CMD;
            ST_CMD:  state <= ST_BELL;
            ST_BELL: state <= ST_RD;
            ST_RD:   state <= ST_CHK;
            ST_CHK: begin
               if (!st_zero) begin
                  if (chain_go) begin
                     cmd_q    <= RST_END_CODE;
                     phase2_q <= 1'b1;
                     state    <= ST_HOLD;
                  end else begin
                     done         <= 1'b1;
                     done_status  <= ram_rdata;
                     done_timeout <= 1'b0;
                     done_fail    <= (ram_rdata != SUCCESS_CODE);
                     state        <= ST_IDLE;
                  end
               end else if (try_zero) begin
                  done         <= 1'b1;
                  done_status  <= 16'h0000;
                  done_timeout <= 1'b1;
                  done_fail    <= 1'b1;
                  state        <= ST_IDLE;
               end else begin
                  state <= ST_GAP;
               end
            end
            ST_GAP:  if (gap_zero)  state <= ST_RD;
            ST_HOLD: if (hold_zero) state <= ST_CLR;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2: the doorbell comes only right after the command word is stored
   assert_bell_after_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      doorbell |-> $past(ram_we && ram_addr == A_CMD));

   // R2: the argument is written only right after the status word was zeroed
   assert_clear_before_arg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && ram_addr == A_ALO) |-> $past(ram_we && ram_addr == A_STAT && ram_wdata == 16'h0000));

   // R3: the first status read follows the doorbell
   assert_read_after_bell_R3: assert property (@(posedge clk) disable iff (!rst_n)
      doorbell |=> (ram_re && ram_addr == A_STAT));

   // R4: a timeout reports a zero status and a failure
   assert_timeout_report_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_timeout) |-> (done_status == 16'h0000 && done_fail));

   // R5: completion is a single-cycle pulse
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: a busy sequencer issues no doorbell in the cycle after completing
   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !doorbell && !ram_re);
endmodule

// File: tb/sim_mbox_cmd_seq.sv
module sim_mbox_cmd_seq;
   localparam int STA  = 0;
   localparam int CMDA = 1;
   localparam int PRA  = 2;
   localparam int MAXP = 4;
   localparam int GAP  = 3;
   localparam int HW   = 4;
   localparam logic [15:0] RSC = 16'h0008;
   localparam logic [15:0] REC = 16'h0009;
   localparam int LN = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_bus_reset = 1'b0;
   logic [15:0] req_cmd = '0;
   logic [31:0] req_param = '0;
   logic [HW-1:0] req_hold = '0;
   logic busy, done, done_timeout, done_fail, ram_we, ram_re, doorbell;
   logic [15:0] done_status, ram_wdata;
   logic [15:0] ram_rdata = '0;
   logic [3:0] ram_addr;

   always #2 clk = ~clk;

   mbox_cmd_seq #(
      .AW(4), .STATUS_ADDR(STA), .CMD_ADDR(CMDA), .PARAM_ADDR(PRA),
      .MAX_POLLS(MAXP), .POLL_GAP(GAP), .HOLD_W(HW),
      .SUCCESS_CODE(16'h0001), .RST_START_CODE(RSC), .RST_END_CODE(REC)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus_reset(req_bus_reset),
      .req_cmd(req_cmd), .req_param(req_param), .req_hold(req_hold), .busy(busy),
      .done(done), .done_status(done_status), .done_timeout(done_timeout),
      .done_fail(done_fail), .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .doorbell(doorbell));

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // processor and RAM model
   logic [15:0] mem [0:15];
   int zr_tab [0:LN-1];
   logic [15:0] rv_tab [0:LN-1];
   logic [15:0] sn_cmd [0:LN-1];
   logic [15:0] sn_lo [0:LN-1];
   logic [15:0] sn_hi [0:LN-1];
   logic [15:0] sn_st [0:LN-1];
   int bells = 0;
   int rdcnt = 0;

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 16'h0;
      for (int i = 0; i < LN; i++) begin
         zr_tab[i] = 0;
         rv_tab[i] = 16'h1;
      end
   end

   always @(posedge clk) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      if (doorbell) begin
         sn_cmd[bells % LN] <= mem[CMDA];
         sn_lo[bells % LN]  <= mem[PRA];
         sn_hi[bells % LN]  <= mem[PRA+1];
         sn_st[bells % LN]  <= mem[STA];
         bells <= bells + 1;
         rdcnt <= 0;
      end
      if (ram_re) begin
         if (int'(ram_addr) == STA && bells > 0 && (rdcnt + 1) > zr_tab[(bells - 1) % LN])
            ram_rdata <= rv_tab[(bells - 1) % LN];
         else
            ram_rdata <= mem[ram_addr];
         rdcnt <= rdcnt + 1;
      end
   end

   // port monitor, sampled at the falling edge
   int cyc = 0;
   int wn = 0, rn = 0, bn = 0, done_cnt = 0;
   int wa [0:LN-1];
   logic [15:0] wd [0:LN-1];
   int wc [0:LN-1];
   int rc [0:LN-1];
   int bc [0:LN-1];
   int d_cyc = 0;
   logic [15:0] d_status = '0;
   bit d_to = 1'b0, d_fail = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (ram_we) begin
            wa[wn % LN] = int'(ram_addr);
            wd[wn % LN] = ram_wdata;
            wc[wn % LN] = cyc;
            wn++;
         end
         if (ram_re) begin
            rc[rn % LN] = cyc;
            rn++;
         end
         if (doorbell) begin
            bc[bn % LN] = cyc;
            bn++;
         end
         if (done) begin
            d_cyc = cyc;
            d_status = done_status;
            d_to = done_timeout;
            d_fail = done_fail;
            done_cnt++;
         end
      end
      cyc++;
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // checks one command phase: writes at w, doorbell b, reads from r
   task automatic chk_phase(input int w, input int b, input int r, input int nr,
                            input logic [15:0] c, input logic [31:0] p);
      bit ok;
      check(wa[w%LN] == STA && wd[w%LN] == 16'h0, "R2 status cleared first", wa[w%LN], STA);
      check(wa[(w+1)%LN] == PRA && wd[(w+1)%LN] == p[15:0] && wc[(w+1)%LN] == wc[w%LN] + 1,
            "R2 argument low half", wd[(w+1)%LN], p[15:0]);
      check(wa[(w+2)%LN] == PRA + 1 && wd[(w+2)%LN] == p[31:16] && wc[(w+2)%LN] == wc[w%LN] + 2,
            "R2 argument high half", wd[(w+2)%LN], p[31:16]);
      check(wa[(w+3)%LN] == CMDA && wd[(w+3)%LN] == c && wc[(w+3)%LN] == wc[w%LN] + 3,
            "R2 command word last", wd[(w+3)%LN], c);
      check(bc[b%LN] == wc[(w+3)%LN] + 1, "R2 doorbell timing", bc[b%LN], wc[(w+3)%LN] + 1);
      check(sn_st[b%LN] == 16'h0 && sn_cmd[b%LN] == c && {sn_hi[b%LN], sn_lo[b%LN]} == p,
            "R2 mailbox contents at doorbell", sn_cmd[b%LN], c);
      check(rc[r%LN] == bc[b%LN] + 1, "R3 first poll after doorbell", rc[r%LN], bc[b%LN] + 1);
      ok = 1'b1;
      for (int i = 1; i < nr; i++) if (rc[(r+i)%LN] != rc[(r+i-1)%LN] + GAP + 2) ok = 1'b0;
      check(ok, "R3 poll spacing", nr, nr);
   endtask

   task automatic wait_done(input int d0);
      int lim = 0;
      while (done_cnt == d0 && lim < 3000) begin
         @(posedge clk);
         lim++;
      end
      repeat (4) @(posedge clk);
   endtask

   task automatic run_single(input logic [15:0] c, input logic [31:0] p, input int z, input logic [15:0] v);
      int w0, r0, b0, d0, nr;
      bit to;
      logic [15:0] es;
      @(posedge clk);
      w0 = wn; r0 = rn; b0 = bn; d0 = done_cnt;
      zr_tab[b0 % LN] = z;
      rv_tab[b0 % LN] = v;
      @(negedge clk);
      req_valid = 1'b1; req_bus_reset = 1'b0; req_cmd = c; req_param = p;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done(d0);
      to = (z >= MAXP);
      nr = to ? MAXP : z + 1;
      es = to ? 16'h0 : v;
      chk_phase(w0, b0, r0, nr, c, p);
      check(rn - r0 == nr, to ? "R4 read budget" : "R3 stops on non-zero", rn - r0, nr);
      check(done_cnt == d0 + 1, "R5 one completion", done_cnt - d0, 1);
      check(d_status == es && d_to == to, to ? "R4 timeout report" : "R5 status report", d_status, es);
      check(d_fail == (es != 16'h1), "R5 failure flag", d_fail, es != 16'h1);
      check(d_cyc == rc[(r0+nr-1)%LN] + 2, "R5 completion latency", d_cyc, rc[(r0+nr-1)%LN] + 2);
   endtask

   task automatic run_reset(input int h, input int z0, input logic [15:0] v0,
                            input int z1, input logic [15:0] v1);
      int w0, r0, b0, d0, nr0, nr1;
      bit to0, to1, go;
      logic [15:0] es;
      @(posedge clk);
      w0 = wn; r0 = rn; b0 = bn; d0 = done_cnt;
      zr_tab[b0 % LN] = z0;       rv_tab[b0 % LN] = v0;
      zr_tab[(b0+1) % LN] = z1;   rv_tab[(b0+1) % LN] = v1;
      @(negedge clk);
      req_valid = 1'b1; req_bus_reset = 1'b1; req_cmd = 16'h5555;
      req_param = 32'hFFFF_FFFF; req_hold = HW'(h);
      @(negedge clk);
      req_valid = 1'b0; req_bus_reset = 1'b0;
      wait_done(d0);
      to0 = (z0 >= MAXP); nr0 = to0 ? MAXP : z0 + 1;
      to1 = (z1 >= MAXP); nr1 = to1 ? MAXP : z1 + 1;
      go = !to0 && (v0 == 16'h1);
      chk_phase(w0, b0, r0, nr0, RSC, 32'h0);
      if (go) begin
         chk_phase(w0 + 4, b0 + 1, r0 + nr0, nr1, REC, 32'h0);
         check(wc[(w0+4)%LN] == rc[(r0+nr0-1)%LN] + h + 3, "R7 hold delay",
               wc[(w0+4)%LN] - rc[(r0+nr0-1)%LN], h + 3);
         check(bn - b0 == 2 && wn - w0 == 8, "R7 two commands issued", bn - b0, 2);
         es = to1 ? 16'h0 : v1;
         check(d_status == es && d_to == to1, "R9 end phase report", d_status, es);
         check(d_fail == (es != 16'h1), "R9 failure flag", d_fail, es != 16'h1);
         check(d_cyc == rc[(r0+nr0+nr1-1)%LN] + 2, "R9 completion latency",
               d_cyc, rc[(r0+nr0+nr1-1)%LN] + 2);
      end else begin
         check(bn - b0 == 1 && wn - w0 == 4, "R8 end command suppressed", bn - b0, 1);
         es = to0 ? 16'h0 : v0;
         check(d_status == es && d_to == to0 && d_fail, "R8 start phase report", d_status, es);
      end
      check(done_cnt == d0 + 1, "R5 one completion per bus reset", done_cnt - d0, 1);
   endtask

   initial begin : watchdog
      while (cyc < 150000 && !finished) @(negedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      int w0, b0, d0;
      repeat (3) @(negedge clk);
      check(!busy && !done && !doorbell && !ram_we && !ram_re, "R1 reset state",
            {busy, done, doorbell, ram_we, ram_re}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy && !done && !doorbell && !ram_we && !ram_re, "R1 idle after reset",
            {busy, done, doorbell, ram_we, ram_re}, 0);

      // sweep zero-read count against completion codes
      for (int z = 0; z <= MAXP; z++) begin
         run_single(16'h0100 + 16'(z), 32'hA5C3_0000 + 32'(z * 7), z, 16'h0001);
         run_single(16'h0200 + 16'(z), 32'h1234_5678 ^ 32'(z), z, 16'h0002);
         run_single(16'h0300 + 16'(z), 32'hFFFF_0001, z, 16'hFFFF);
      end

      // bus reset: hold values, failures and timeouts in each phase
      run_reset(0, 0, 16'h1, 0, 16'h1);
      run_reset(2, 1, 16'h1, 2, 16'h1);
      run_reset(5, 0, 16'h1, 1, 16'h7);
      run_reset(15, 2, 16'h1, 0, 16'h1);
      run_reset(3, 0, 16'h3, 0, 16'h1);
      run_reset(1, MAXP, 16'h1, 0, 16'h1);
      run_reset(4, 1, 16'h1, MAXP, 16'h1);

      // R6: requests while busy are ignored
      @(posedge clk);
      w0 = wn; b0 = bn; d0 = done_cnt;
      zr_tab[b0 % LN] = 2;
      rv_tab[b0 % LN] = 16'h1;
      @(negedge clk);
      req_valid = 1'b1; req_cmd = 16'h0123; req_param = 32'h0000_4444;
      @(negedge clk);
      req_cmd = 16'hBEEF; req_param = 32'hDEAD_0000; req_bus_reset = 1'b1;
      repeat (8) @(negedge clk);
      req_valid = 1'b0; req_bus_reset = 1'b0;
      wait_done(d0);
      repeat (20) @(posedge clk);
      check(done_cnt == d0 + 1, "R6 no extra completion", done_cnt - d0, 1);
      check(wn - w0 == 4 && bn - b0 == 1, "R6 no extra writes or doorbell", wn - w0, 4);
      check(sn_cmd[b0 % LN] == 16'h0123 && sn_lo[b0 % LN] == 16'h4444, "R6 first request kept",
            sn_cmd[b0 % LN], 16'h0123);
      check(!busy, "R6 idle afterwards", busy, 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule